// File: doc/BRIEF.md
# Six-digit decimal stopwatch core with overflow warning

The core keeps elapsed time as six BCD digits: hundredths, tenths, seconds, tens of seconds, minutes and tens of minutes. The range runs from 00:00.00 to 59:59.99. The core runs on a single 10 MHz clock. A prescaler turns that clock into a one-cycle 100 Hz enable, and the enable walks a carry chain of modulus-10 and modulus-6 digits. No derived clocks are used.

A run/hold input freezes the count and the prescaler together. After a hold, timing resumes from exactly the point where it stopped. An active-low clear zeroes everything at once.

During the last ten seconds before the count overflows, the beeper output carries a square tone. The tone comes from a free-running divider and is unaffected by hold. Display decoding and the sound hardware live outside this block.

Top module: `stopwatch_core`

## Requirements
- R1: While `clr_n` is low and after it returns high, before any tick, all six digits read 0 and `beep` is low.
- R2: Digit radices from `digit0` up to `digit5` are 10, 10, 10, 6, 10, 6 (set by `RADIX`, 4 bits per digit, `digit0` in the low nibble). `digit0` advances by one on every tick. A higher digit advances by one on a tick only when every lower digit is at its maximum, and a digit at its maximum returns to 0 at that tick.
- R3: Release of `clr_n` passes through a two-stage synchronizer. Counting starts on the third rising edge after release, and the first tick lands after `TICK_DIV` counted edges. With the default of 100000, the tick rate is 100 Hz from 10 MHz.
- R4: Taking `clr_n` low forces every digit to 0 at once, without waiting for a clock edge.
- R5: While `hold` is high at a rising edge, no digit changes at that edge.
- R6: The prescaler also stops while `hold` is high. The number of ticks since clear is therefore floor(N / `TICK_DIV`), where N counts only the edges sampled with `hold` low.
- R7: From 59:59.99 the next tick gives 00:00.00, and counting continues.
- R8: `beep` can be high only while the digits read 59:5x.xx, meaning `digit5`=5, `digit4`=9 and `digit3`=5. At every other count it stays low.
- R9: Inside that window, `beep` follows a square wave that flips every `TONE_HALF` cycles. With the default of 10000, this gives 500 Hz. The wave starts low and free-runs from the third edge after release, whether or not the count is on hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz system clock |
| clr_n | input | 1 | Asynchronous active-low clear, release synchronized |
| hold | input | 1 | High freezes the count and the prescaler; low runs |
| digit0 | output | 4 | Hundredths of a second, BCD |
| digit1 | output | 4 | Tenths of a second, BCD |
| digit2 | output | 4 | Seconds units, BCD |
| digit3 | output | 4 | Tens of seconds, BCD |
| digit4 | output | 4 | Minutes units, BCD |
| digit5 | output | 4 | Tens of minutes, BCD |
| beep | output | 1 | Warning tone drive |

## Verification
The assertions assume that `hold` is synchronous to `clk` and settled at each rising edge. They also assume that `clr_n` may fall at any time but is released away from an edge. The bench changes `hold` and releases `clr_n` only on falling edges, and it drops `clr_n` on a falling edge so that the asynchronous zeroing can be seen before the next rising edge.

The bench uses a small radix set and a short prescaler, so that several complete hours, with their wrap and warning windows, fit in the run. It compares every digit and `beep` on every cycle against a mixed-radix breakdown of the counted edges.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned NDIG = 6;

  typedef logic [3:0] bcd_t;

  // Radix of each digit, low nibble = hundredths
  localparam logic [4*NDIG-1:0] DEFAULT_RADIX =
    {4'd6, 4'd10, 4'd6, 4'd10, 4'd10, 4'd10};

  // Largest value of each digit for a radix vector
  function automatic logic [4*NDIG-1:0] top_values(input logic [4*NDIG-1:0] rad);
    logic [4*NDIG-1:0] res;
    res = '0;
    for (int i = 0; i < NDIG; i++) begin
      res[4*i +: 4] = rad[4*i +: 4] - 4'd1;
    end
    return res;
  endfunction
endpackage

// File: rtl/sw_reset_sync.sv
module sw_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    s1_d = 1'b1;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
  parameter int unsigned DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (run) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && at_last;

  // R3: phase counter never leaves its range
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R6: phase is frozen when not running
  p_phase_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
endmodule

// File: rtl/sw_digit.sv
module sw_digit
  import sw_pkg::*;
#(
  parameter int unsigned RADIX = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output bcd_t q,
  output logic at_max
);
  localparam bcd_t TOP = 4'(RADIX - 1);

  bcd_t q_q, q_d;

  assign at_max = (q_q == TOP);

  always_comb begin
    q_d = q_q;
    if (en) begin
      if (at_max) q_d = '0;
      else        q_d = q_q + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  // R2: a digit stays within its radix
  p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_q <= TOP);

  // R2: an enabled digit below its top steps by exactly one
  p_digit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !at_max) |=> (q_q == $past(q_q) + 4'd1));

  // R2: an enabled digit at its top returns to zero
  p_digit_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && at_max) |=> (q_q == 4'd0));
endmodule

// File: rtl/sw_tone.sv
module sw_tone #(
  parameter int unsigned HALF = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic sq
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sq_q, sq_d;
  logic          flip;

  assign flip = (cnt_q == LAST);

  always_comb begin
    cnt_d = flip ? '0 : cnt_q + 1'b1;
    sq_d  = flip ? !sq_q : sq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sq_q  <= sq_d;
    end
  end

  assign sq = sq_q;

  // R9: the tone only changes at the end of a half period
  p_tone_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flip |=> $stable(sq_q));

  // R9: the tone changes at every end of a half period
  p_tone_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (sq_q != $past(sq_q)));
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
  import sw_pkg::*;
#(
  parameter int unsigned          TICK_DIV  = 100000,
  parameter int unsigned          TONE_HALF = 10000,
  parameter logic [4*NDIG-1:0]    RADIX     = DEFAULT_RADIX
) (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       hold,
  output logic [3:0] digit0,
  output logic [3:0] digit1,
  output logic [3:0] digit2,
  output logic [3:0] digit3,
  output logic [3:0] digit4,
  output logic [3:0] digit5,
  output logic       beep
);
  localparam logic [4*NDIG-1:0] TOPS = top_values(RADIX);

  logic              rst_sync_n;
  logic              run;
  logic              tick;
  logic              tone_sq;
  logic              warn;
  logic [NDIG-1:0]   en;
  logic [NDIG-1:0]   at_max;
  logic [4*NDIG-1:0] dig_flat;

  sw_reset_sync u_rsync (
    .clk    (clk),
    .arst_n (clr_n),
    .srst_n (rst_sync_n)
  );

  assign run = !hold;

  sw_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tick  (tick)
  );

  assign en[0] = tick;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    localparam int unsigned R = int'(RADIX[4*i +: 4]);
    if (i > 0) begin : g_carry
      assign en[i] = en[i-1] && at_max[i-1];
    end
    sw_digit #(.RADIX(R)) u_digit (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en     (en[i]),
      .q      (dig_flat[4*i +: 4]),
      .at_max (at_max[i])
    );
  end

  sw_tone #(.HALF(TONE_HALF)) u_tone (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sq    (tone_sq)
  );

  // Last ten seconds of the range: top three digits all at their maxima
  assign warn = at_max[NDIG-1] && at_max[NDIG-2] && at_max[NDIG-3];
  assign beep = warn && tone_sq;

  assign digit0 = dig_flat[3:0];
  assign digit1 = dig_flat[7:4];
  assign digit2 = dig_flat[11:8];
  assign digit3 = dig_flat[15:12];
  assign digit4 = dig_flat[19:16];
  assign digit5 = dig_flat[23:20];

  // R5: hold keeps every digit
  p_hold_keeps_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold |=> $stable(dig_flat));

  // R8: tone only inside 59:5x.xx
  p_beep_window_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beep |-> (digit5 == TOPS[23:20] && digit4 == TOPS[19:16] &&
              digit3 == TOPS[15:12]));

  // R7: top of range wraps to zero on the next tick
  p_range_wrap_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && dig_flat == TOPS) |=> (dig_flat == '0));
endmodule

// File: tb/stopwatch_core_bench.sv
module stopwatch_core_bench;
  localparam int DIV  = 3;
  localparam int HALF = 5;
  localparam int M0 = 2, M1 = 2, M2 = 3, M3 = 6, M4 = 10, M5 = 6;
  localparam logic [23:0] RAD = {4'd6, 4'd10, 4'd6, 4'd3, 4'd2, 4'd2};
  localparam int TOTAL = M0 * M1 * M2 * M3 * M4 * M5;
  localparam int WIN   = M0 * M1 * M2;

  logic clk   = 1'b0;
  logic clr_n = 1'b0;
  logic hold  = 1'b0;
  logic [3:0] d0, d1, d2, d3, d4, d5;
  logic beep;

  int errors = 0;
  int checks = 0;
  int rel, run_cyc, tone_cyc;
  string phase = "R1";

  always #4 clk = ~clk;

  stopwatch_core #(.TICK_DIV(DIV), .TONE_HALF(HALF), .RADIX(RAD)) u_stopwatch_core (
    .clk(clk), .clr_n(clr_n), .hold(hold),
    .digit0(d0), .digit1(d1), .digit2(d2), .digit3(d3), .digit4(d4), .digit5(d5),
    .beep(beep)
  );

  // Arithmetic model of elapsed edges
  always @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      rel <= 0; run_cyc <= 0; tone_cyc <= 0;
    end else if (rel < 2) begin
      rel <= rel + 1;
    end else begin
      tone_cyc <= tone_cyc + 1;
      if (!hold) run_cyc <= run_cyc + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int t, e0, e1, e2, e3, e4, e5, eb;
    bit win;
    t  = (run_cyc / DIV) % TOTAL;
    e0 = t % M0;
    e1 = (t / M0) % M1;
    e2 = (t / (M0 * M1)) % M2;
    e3 = (t / (M0 * M1 * M2)) % M3;
    e4 = (t / (M0 * M1 * M2 * M3)) % M4;
    e5 = (t / (M0 * M1 * M2 * M3 * M4)) % M5;
    win = (t >= TOTAL - WIN);
    eb = (win && ((tone_cyc / HALF) % 2 == 1)) ? 1 : 0;
    check(phase, "digit0", int'(d0), e0);
    check(phase, "digit1", int'(d1), e1);
    check(phase, "digit2", int'(d2), e2);
    check(phase, "digit3", int'(d3), e3);
    check(phase, "digit4", int'(d4), e4);
    check(phase, "digit5", int'(d5), e5);
    check(win ? "R9" : "R8", "beep", int'(beep), eb);
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: clear state
    repeat (3) @(negedge clk);
    check("R1", "digits", int'({d5, d4, d3, d2, d1, d0}), 0);
    check("R1", "beep", int'(beep), 0);
    clr_n = 1'b1;
    phase = "R3"; run(40);
    phase = "R2"; run(3000);
    phase = "R5"; hold = 1'b1; run(50);
    hold = 1'b0;
    phase = "R6"; run(500);
    for (int k = 0; k < 60; k++) begin
      hold = ~hold;
      run(7);
    end
    hold = 1'b0;
    phase = "R7"; run(13000);
    // R4: asynchronous clear seen before the next edge
    check("R4", "digits nonzero before clear", int'({d5, d4, d3, d2, d1, d0} != 0), 1);
    clr_n = 1'b0;
    #1;
    check("R4", "digits at clear", int'({d5, d4, d3, d2, d1, d0}), 0);
    phase = "R4"; run(3);
    clr_n = 1'b1;
    phase = "R3"; run(30);
    hold = 1'b1;
    phase = "R6"; run(20);
    hold = 1'b0; run(100);
    phase = "R7"; run(13000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule